// File: doc/BRIEF.md
# DRAM Controller Operating-State Sequencer

This block holds the operating state of a DRAM controller and moves it between four states: memory initialisation (INIT), configuration (CONFIG), normal traffic (ACCESS) and low power (LOWPWR). Software steers it with a small command port. A command is offered with `cmd_valid` and a two-bit code. In the same cycle the block answers with `cmd_ack` if the command is legal in the current state, or with `cmd_nack` if it is not.

Every accepted move takes a programmable number of cycles, given by `lat_cycles` at the moment of acceptance. This stands in for the DRAM and PHY acknowledgements that a real controller waits for. During that time `busy` is high and the reported state still shows the state being left.

Only a few paths exist:
- INIT and ACCESS go to CONFIG on a configure command.
- CONFIG goes to ACCESS on a go command.
- LOWPWR goes back to ACCESS on a wake command.
- ACCESS drops to LOWPWR when hardware low-power entry is enabled and requested.

Software that wants CONFIG while in LOWPWR must wake the block first and then configure it. Software that wants ACCESS from INIT must configure first and then issue go.

Top module: `mcos_opstate_ctrl`

## Requirements
- R1: After reset `status` is INIT, `busy` is 0 and `cmd_ready` is 1.
- R2: `status` encodes the state as INIT=2'b00, CONFIG=2'b01, ACCESS=2'b10 and LOWPWR=2'b11. It changes only along the edges INIT→CONFIG, ACCESS→CONFIG, CONFIG→ACCESS, LOWPWR→ACCESS and ACCESS→LOWPWR.
- R3: The configure command (code 2'b01), offered in INIT or ACCESS, is acknowledged and leads to CONFIG.
- R4: The go command (code 2'b10), offered in CONFIG, is acknowledged and leads to ACCESS.
- R5: The wake command (code 2'b11), offered in LOWPWR, is acknowledged and leads to ACCESS.
- R6: An illegal command is answered with `cmd_nack` and has no effect: `status` is unchanged and `busy` stays 0. Code 2'b00 is illegal in every state, and every code outside the edges of R3 to R5 is illegal.
- R7: A move accepted with `lat_cycles` = L (L ≥ 1) keeps `busy` high and `status` at the old value for L cycles after the accepting edge. The new state appears on the L-th edge, together with `busy` returning to 0. L = 0 behaves as L = 1.
- R8: While `busy` is high, `cmd_ready` is 0 and no command is acknowledged, refused or acted on.
- R9: With `hw_lp_en` and `hw_lp_req` both high, an idle block in ACCESS starts a move to LOWPWR. The request has no effect when `hw_lp_en` is 0 or when the state is not ACCESS.
- R10: A legal command accepted in the same cycle as a hardware low-power request takes priority. An illegal command does not block the request.
- R11: `cmd_ack` and `cmd_nack` are never high together. Either one is high only while `cmd_valid` and `cmd_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered this cycle |
| cmd_code | input | 2 | 00 none, 01 configure, 10 go, 11 wake |
| lat_cycles | input | LAT_W | Duration of a move accepted this cycle |
| hw_lp_en | input | 1 | Enables hardware low-power entry |
| hw_lp_req | input | 1 | Hardware low-power entry request |
| cmd_ready | output | 1 | Block is idle and will answer a command |
| cmd_ack | output | 1 | Offered command is legal and accepted |
| cmd_nack | output | 1 | Offered command is illegal and ignored |
| busy | output | 1 | A move is in progress |
| status | output | 2 | Current state, encoded as in R2 |

## Verification
The assertions assume that every input is known at each rising edge. They also assume that `cmd_code` and the low-power inputs are meaningful only in the cycle in which they are sampled. The checker tracks the destination of each move from the ports alone and makes no assumption about how long a move lasts.

The bench changes inputs only on falling edges, so each value is settled well before the edge that samples it. It drops `cmd_valid` right after each accepting edge. During a move it offers commands only to show that they are refused.

// File: rtl/mcos_pkg.sv
package mcos_pkg;

    typedef enum logic [1:0] {
        ST_INIT   = 2'b00,
        ST_CONFIG = 2'b01,
        ST_ACCESS = 2'b10,
        ST_LOWPWR = 2'b11
    } op_state_t;

    typedef enum logic [1:0] {
        OP_NOP  = 2'b00,
        OP_CFG  = 2'b01,
        OP_GO   = 2'b10,
        OP_WAKE = 2'b11
    } op_cmd_t;

endpackage

// File: rtl/mcos_cmd_check.sv
module mcos_cmd_check
    import mcos_pkg::*;
(
    input  op_state_t  cur_state,
    input  logic [1:0] code,
    output logic       legal,
    output op_state_t  dest
);

    // Legality table: each state lists the one code that may leave it
    always_comb begin
        legal = 1'b0;
        dest  = cur_state;
        unique case (cur_state)
            ST_INIT: begin
                if (code == OP_CFG) begin
                    legal = 1'b1;
                    dest  = ST_CONFIG;
                end
            end
            ST_CONFIG: begin
                if (code == OP_GO) begin
                    legal = 1'b1;
                    dest  = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                if (code == OP_CFG) begin
                    legal = 1'b1;
                    dest  = ST_CONFIG;
                end
            end
            ST_LOWPWR: begin
                if (code == OP_WAKE) begin
                    legal = 1'b1;
                    dest  = ST_ACCESS;
                end
            end
            default: begin
                legal = 1'b0;
                dest  = cur_state;
            end
        endcase
    end

endmodule

// File: rtl/mcos_lat_timer.sv
module mcos_lat_timer #(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LAT_W-1:0] lat_in,
    output logic             busy,
    output logic             done
);

    localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

    logic [LAT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= (lat_in == '0) ? ONE : lat_in;
        end else if (busy_q) begin
            if (cnt_q == ONE) begin
                busy_q <= 1'b0;
            end
            cnt_q <= cnt_q - ONE;
        end
    end

    always_comb begin
        busy = busy_q;
        done = busy_q && (cnt_q == ONE);
    end

endmodule

// File: rtl/mcos_opstate_ctrl.sv
module mcos_opstate_ctrl
    import mcos_pkg::*;
#(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_code,
    input  logic [LAT_W-1:0] lat_cycles,
    input  logic             hw_lp_en,
    input  logic             hw_lp_req,
    output logic             cmd_ready,
    output logic             cmd_ack,
    output logic             cmd_nack,
    output logic             busy,
    output logic [1:0]       status
);

    op_state_t state_q;
    op_state_t target_q;
    op_state_t cmd_dest;
    logic      cmd_legal;
    logic      sw_start;
    logic      hw_start;
    logic      move_start;
    logic      move_done;
    logic      tmr_busy;

    mcos_cmd_check u_check (
        .cur_state (state_q),
        .code      (cmd_code),
        .legal     (cmd_legal),
        .dest      (cmd_dest)
    );

    mcos_lat_timer #(.LAT_W(LAT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (move_start),
        .lat_in (lat_cycles),
        .busy   (tmr_busy),
        .done   (move_done)
    );

    // Start of a move: a legal command wins over a hardware low-power request
    always_comb begin
        sw_start   = cmd_valid && !tmr_busy && cmd_legal;
        hw_start   = !tmr_busy && (state_q == ST_ACCESS) && hw_lp_en
                     && hw_lp_req && !sw_start;
        move_start = sw_start || hw_start;
    end

    // State register: the destination is latched at start and applied at done
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_INIT;
            target_q <= ST_INIT;
        end else begin
            if (sw_start) begin
                target_q <= cmd_dest;
            end else if (hw_start) begin
                target_q <= ST_LOWPWR;
            end
            if (move_done) begin
                state_q <= target_q;
            end
        end
    end

    // Outputs
    always_comb begin
        cmd_ready = !tmr_busy;
        cmd_ack   = cmd_valid && !tmr_busy && cmd_legal;
        cmd_nack  = cmd_valid && !tmr_busy && !cmd_legal;
        busy      = tmr_busy;
        status    = state_q;
    end

endmodule

// File: rtl/mcos_opstate_sva.sv
module mcos_opstate_sva #(
    parameter int LAT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [1:0]       cmd_code,
    input logic [LAT_W-1:0] lat_cycles,
    input logic             hw_lp_en,
    input logic             hw_lp_req,
    input logic             cmd_ready,
    input logic             cmd_ack,
    input logic             cmd_nack,
    input logic             busy,
    input logic [1:0]       status
);

    logic [1:0] chk_tgt;
    logic       hw_cond;

    assign hw_cond = !busy && status == 2'b10 && hw_lp_en && hw_lp_req && !cmd_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_tgt <= 2'b00;
        end else if (cmd_ack) begin
            chk_tgt <= (cmd_code == 2'b01) ? 2'b01 : 2'b10;
        end else if (hw_cond) begin
            chk_tgt <= 2'b11;
        end
    end

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ack && cmd_nack));

    a_r11_answer_needs_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ack || cmd_nack) |-> (cmd_valid && cmd_ready));

    a_r8_silent_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!cmd_ack && !cmd_nack && !cmd_ready));

    a_r6_nack_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_nack && !hw_cond |=> (!busy && $stable(status)));

    a_r3_ack_starts_move: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack |=> busy);

    a_r9_hw_entry_starts: assert property (@(posedge clk) disable iff (!rst_n)
        hw_cond |=> busy);

    a_r7_change_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status) |-> $fell(busy));

    a_r4_lands_on_target: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (status == chk_tgt));

    a_r2_legal_edges: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status) |->
            (($past(status) == 2'b00) && (status == 2'b01)) ||
            (($past(status) == 2'b10) && (status == 2'b01)) ||
            (($past(status) == 2'b01) && (status == 2'b10)) ||
            (($past(status) == 2'b11) && (status == 2'b10)) ||
            (($past(status) == 2'b10) && (status == 2'b11)));

endmodule

bind mcos_opstate_ctrl mcos_opstate_sva #(.LAT_W(LAT_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .lat_cycles (lat_cycles),
    .hw_lp_en   (hw_lp_en),
    .hw_lp_req  (hw_lp_req),
    .cmd_ready  (cmd_ready),
    .cmd_ack    (cmd_ack),
    .cmd_nack   (cmd_nack),
    .busy       (busy),
    .status     (status)
);

// File: tb/tb_mcos_opstate_ctrl.sv
module tb_mcos_opstate_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LAT_W      = 4;

    logic             clk;
    logic             rst_n;
    logic             cmd_valid;
    logic [1:0]       cmd_code;
    logic [LAT_W-1:0] lat_cycles;
    logic             hw_lp_en;
    logic             hw_lp_req;
    logic             cmd_ready;
    logic             cmd_ack;
    logic             cmd_nack;
    logic             busy;
    logic [1:0]       status;

    int checks = 0;
    int errors = 0;
    int m_state = 0;

    mcos_opstate_ctrl #(.LAT_W(LAT_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .lat_cycles (lat_cycles),
        .hw_lp_en   (hw_lp_en),
        .hw_lp_req  (hw_lp_req),
        .cmd_ready  (cmd_ready),
        .cmd_ack    (cmd_ack),
        .cmd_nack   (cmd_nack),
        .busy       (busy),
        .status     (status)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit is_legal(input int st, input int code);
        return (code == 1 && (st == 0 || st == 2)) || (code == 2 && st == 1) ||
               (code == 3 && st == 3);
    endfunction

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_code = 2'b00;
        lat_cycles = '0; hw_lp_en = 1'b0; hw_lp_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_state = 0;
    endtask

    // Called on the falling edge right after the accepting edge
    task automatic track(input int nw, input int lat, input bit poke, input string tag);
        int eff;
        eff = (lat == 0) ? 1 : lat;
        chk("R7", {tag, " busy after accept"}, busy, 1);
        chk("R7", {tag, " old status held"}, status, m_state);
        if (poke) begin
            cmd_valid = 1'b1; cmd_code = 2'b10;
            #1;
            chk("R8", "ready while busy", cmd_ready, 0);
            chk("R8", "ack while busy", cmd_ack, 0);
            chk("R8", "nack while busy", cmd_nack, 0);
        end
        for (int k = 1; k < eff; k++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            chk("R7", {tag, " busy mid move"}, busy, 1);
            chk("R7", {tag, " status mid move"}, status, m_state);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R7", {tag, " busy at end"}, busy, 0);
        chk(tag, "status at end", status, nw);
        m_state = nw;
    endtask

    task automatic send(input int code, input int lat, input bit poke, input string tag);
        bit lg;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code[1:0]; lat_cycles = lat[LAT_W-1:0];
        #1;
        lg = is_legal(m_state, code);
        chk("R11", {tag, " ack"}, cmd_ack, int'(lg));
        chk("R11", {tag, " nack"}, cmd_nack, int'(!lg));
        @(negedge clk);
        cmd_valid = 1'b0;
        if (lg) begin
            track((code == 1) ? 1 : 2, lat, poke, tag);
        end else begin
            chk("R6", "busy after illegal", busy, 0);
            chk("R6", "status after illegal", status, m_state);
        end
    endtask

    task automatic hw_enter(input int lat);
        @(negedge clk);
        hw_lp_en = 1'b1; hw_lp_req = 1'b1; lat_cycles = lat[LAT_W-1:0];
        @(negedge clk);
        hw_lp_en = 1'b0; hw_lp_req = 1'b0;
        track(3, lat, 1'b0, "R9");
    endtask

    task automatic goto_state(input int st);
        if (st >= 1) send(1, 1, 1'b0, "R3");
        if (st >= 2) send(2, 1, 1'b0, "R4");
        if (st == 3) hw_enter(1);
        chk("R2", "status encoding", status, st);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        reset_dut();
        #1;
        chk("R1", "status after reset", status, 0);
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "ready after reset", cmd_ready, 1);

        // Sweep every state x every code x small latencies
        for (int st = 0; st < 4; st++) begin
            for (int code = 0; code < 4; code++) begin
                for (int lat = 0; lat < 4; lat++) begin
                    string tag;
                    reset_dut();
                    goto_state(st);
                    if (!is_legal(st, code)) tag = "R6";
                    else if (code == 1) tag = "R3";
                    else if (code == 2) tag = "R4";
                    else tag = "R5";
                    send(code, lat, lat == 2, tag);
                end
            end
        end

        // Longest latency
        reset_dut();
        send(1, 15, 1'b1, "R3");

        // R9: request without enable is ignored in ACCESS
        reset_dut();
        goto_state(2);
        @(negedge clk);
        hw_lp_en = 1'b0; hw_lp_req = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk("R9", "no entry without enable busy", busy, 0);
            chk("R9", "no entry without enable status", status, 2);
        end
        hw_lp_req = 1'b0;

        // R9: enabled request outside ACCESS is ignored
        reset_dut();
        goto_state(1);
        @(negedge clk);
        hw_lp_en = 1'b1; hw_lp_req = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R9", "no entry from config busy", busy, 0);
            chk("R9", "no entry from config status", status, 1);
        end
        hw_lp_en = 1'b0; hw_lp_req = 1'b0;

        // R10: legal configure command wins over request
        reset_dut();
        goto_state(2);
        @(negedge clk);
        hw_lp_en = 1'b1; hw_lp_req = 1'b1;
        cmd_valid = 1'b1; cmd_code = 2'b01; lat_cycles = 4'd3;
        #1;
        chk("R10", "ack with request", cmd_ack, 1);
        @(negedge clk);
        cmd_valid = 1'b0; hw_lp_en = 1'b0; hw_lp_req = 1'b0;
        track(1, 3, 1'b0, "R10");

        // R10: illegal go command does not block request
        reset_dut();
        goto_state(2);
        @(negedge clk);
        hw_lp_en = 1'b1; hw_lp_req = 1'b1;
        cmd_valid = 1'b1; cmd_code = 2'b10; lat_cycles = 4'd2;
        #1;
        chk("R10", "nack with request", cmd_nack, 1);
        @(negedge clk);
        cmd_valid = 1'b0; hw_lp_en = 1'b0; hw_lp_req = 1'b0;
        track(3, 2, 1'b0, "R10");

        // R5 then R3: low power to config passes through access
        send(1, 1, 1'b0, "R6");
        send(3, 2, 1'b0, "R5");
        send(1, 2, 1'b0, "R3");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule